// File: doc/BRIEF.md
# Radix-8 Carry-Select Booth Recoder

This block turns a multiplier operand held in partial carry-save form into radix-8 Booth digits. It does not first resolve that operand to plain binary. The operand is an n-bit word `opnd_v` plus one carry bit per k-bit fragment. Fragment `i` carries its bit at weight 2^(i*k). The value being recoded is `opnd_v + sum(frag_cy[i] * 2^(i*k))`.

The operand is cut into 3-bit cells. Each cell has two recoders that work in parallel. One recodes the cell's bits as they are. The other recodes them with one added. A control signal arriving from below picks which of the two results is used. At the lowest cell of a fragment, that control is the fragment's carry bit. Above it, inside the fragment, the control is the AND of the control entering the cell below and that cell's all-ones condition. Each cell passes its true top bit up to the next cell, where it becomes that cell's Booth overlap bit.

The block is purely combinational. Each digit is emitted as a sign bit and a one-hot magnitude, ready for a partial-product selector.

Top module: `booth8_cs_recoder`

## Requirements
- R1: With K=3, the sum over p of digit(p)*8^p equals `opnd_v + sum(frag_cy[i]*2^(3i))`.
- R2: With K=6, the same sum equals `opnd_v + sum(frag_cy[i]*2^(6i))`. This exercises control passed between cells inside a fragment.
- R3: For each digit p, `dig_mag[5p+4:5p]` is one-hot. Bit 0 means 0, bit 1 means 1X, bit 2 means 2X, bit 3 means 3X and bit 4 means 4X.
- R4: A digit whose magnitude is zero always has `dig_neg[p]` = 0.
- R5: Let w be the resolved operand value and t3..t0 = w[3p+2], w[3p+1], w[3p], w[3p-1]. Then digit p equals -4*t3 + 2*t2 + t1 + t0. `dig_neg[p]` = 1 means the digit is negative.
- R6: Digit 0 uses an implicit 0 below bit 0 as its overlap bit.
- R7: The number of digits is P = (N+4)/3, which covers the unsigned value plus carries. The top digit is never negative.
- R8: The plus-one recoding of a cell sends its carry to the next cell only when all three of that cell's operand bits are one.
- R9: When every fragment carry is 0, the digits are the plain radix-8 Booth recoding of `opnd_v`. An all-zero input gives all-zero digits.
- R10: Operand contract: K is a multiple of 3, and N is a multiple of K. A fragment whose operand bits are all ones has its carry clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_v | input | N | Sum word of the partial carry-save operand |
| frag_cy | input | N/K | One carry per fragment; bit i has weight 2^(i*K) |
| dig_neg | output | P | Sign of each Booth digit; 1 means negative |
| dig_mag | output | 5*P | One-hot magnitude per digit, 5 bits per digit, digit 0 lowest |

## Verification
The bench targets the following corner cases:

- **Cells whose three bits are all ones under a fragment carry.** If the carry out of such a cell were lost, or sent on when it should not be, the digit above would be off by one. The reconstructed value would then be off by a multiple of 8.
- **Fragments of 6 bits.** The upper cell of each fragment depends on the AND chain rather than on a carry input. If the chain were wired to the wrong carry, only the K=6 instance would disagree.
- **Overlap bit taken from the raw bit instead of the incremented one.** Every digit is compared to the Booth digit of the resolved value, so a wrong overlap bit shows up as a single digit off by one.
- **Negative zero and top-digit sign.** These are checked directly on every vector.

// File: rtl/booth8_cs_recoder.sv
module booth8_cs_recoder #(
  parameter int N = 12,
  parameter int K = 3
) (
  input  logic [N-1:0]           opnd_v,
  input  logic [N/K-1:0]         frag_cy,
  output logic [(N+4)/3-1:0]     dig_neg,
  output logic [5*((N+4)/3)-1:0] dig_mag
);
  localparam int F = N / K;
  localparam int P = (N + 4) / 3;
  localparam int W = 3 * P;

  function automatic logic [5:0] booth_enc(input logic [3:0] t);
    int d;
    int m;
    d = -4 * int'(t[3]) + 2 * int'(t[2]) + int'(t[1]) + int'(t[0]);
    m = (d < 0) ? -d : d;
    booth_enc = {(d < 0), 5'(5'b00001 << m)};
  endfunction

  logic [W-1:0] ve;
  logic [P-1:0] ctl;
  logic [P-2:0] hi;
  logic [P-2:0] allone;

  assign ve = {{(W-N){1'b0}}, opnd_v};

  for (genvar p = 0; p < P; p++) begin : g_cell
    logic [2:0] raw;
    logic [2:0] inc;
    logic       lsb;
    logic [5:0] enc0;
    logic [5:0] enc1;
    logic [5:0] pick;

    assign raw = ve[3*p +: 3];
    assign inc = raw + 3'd1;

    if (p == 0) begin : g_lsb0
      assign lsb = 1'b0;
    end else begin : g_lsbn
      assign lsb = hi[p-1];
    end

    if (((3*p) % K == 0) && ((3*p) / K < F)) begin : g_fragbase
      assign ctl[p] = frag_cy[(3*p)/K];
    end else begin : g_chain
      assign ctl[p] = ctl[p-1] & allone[p-1];
    end

    if (p < P-1) begin : g_fwd
      assign allone[p] = &raw;
      assign hi[p]     = ctl[p] ? inc[2] : raw[2];
    end

    assign enc0 = booth_enc({raw, lsb});
    assign enc1 = booth_enc({inc, lsb});
    assign pick = ctl[p] ? enc1 : enc0;

    assign dig_neg[p]       = pick[5];
    assign dig_mag[5*p +: 5] = pick[4:0];
  end
endmodule

// File: rtl/booth8_cs_recoder_chk.sv
module booth8_cs_recoder_chk #(
  parameter int N = 12,
  parameter int K = 3
) (
  input logic [N-1:0]           opnd_v,
  input logic [N/K-1:0]         frag_cy,
  input logic [(N+4)/3-1:0]     dig_neg,
  input logic [5*((N+4)/3)-1:0] dig_mag
);
  localparam int P = (N + 4) / 3;

  for (genvar p = 0; p < P; p++) begin : g_dig
    always_comb begin
      AST_MAG_ONEHOT: assert ($onehot(dig_mag[5*p +: 5])) else $error("digit %0d magnitude not one-hot", p); // R3
      AST_NO_NEG_ZERO: assert (!(dig_mag[5*p] && dig_neg[p])) else $error("digit %0d negative zero", p); // R4
      AST_ZERO_IN: assert (!((opnd_v == '0) && (frag_cy == '0)) || dig_mag[5*p]) else $error("digit %0d nonzero for zero input", p); // R9
    end
  end

  always_comb begin
    AST_TOP_NONNEG: assert (!dig_neg[P-1]) else $error("top digit negative"); // R7
    AST_LOW_ZERO: assert (!((opnd_v[2:0] == 3'b000) && !frag_cy[0]) || dig_mag[0]) else $error("digit 0 not zero"); // R6
  end
endmodule

bind booth8_cs_recoder booth8_cs_recoder_chk #(.N(N), .K(K)) u_chk (.*);

// File: tb/booth8_cs_recoder_bench.sv
module booth8_cs_recoder_bench;
  localparam int N  = 12;
  localparam int P  = (N + 4) / 3;
  localparam int F3 = N / 3;
  localparam int F6 = N / 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]    v;
  logic [F3-1:0]   cy3;
  logic [F6-1:0]   cy6;
  logic [P-1:0]    neg3, neg6;
  logic [5*P-1:0]  mag3, mag6;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  booth8_cs_recoder #(.N(N), .K(3)) u_booth8_cs_recoder (
    .opnd_v(v), .frag_cy(cy3), .dig_neg(neg3), .dig_mag(mag3));
  booth8_cs_recoder #(.N(N), .K(6)) u_booth8_cs_recoder_k6 (
    .opnd_v(v), .frag_cy(cy6), .dig_neg(neg6), .dig_mag(mag6));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (v=%h cy3=%b cy6=%b)", req, act, exp, v, cy3, cy6);
    end
  endtask

  function automatic int dval(logic n, logic [4:0] m);
    if ($countones(m) != 1) return 99;
    for (int i = 0; i < 5; i++) if (m[i]) return n ? -i : i;
    return 99;
  endfunction

  function automatic int exp_digit(int w, int p);
    int t0;
    t0 = (p == 0) ? 0 : ((w >> (3*p-1)) & 1);
    return -4 * ((w >> (3*p+2)) & 1) + 2 * ((w >> (3*p+1)) & 1) + ((w >> (3*p)) & 1) + t0;
  endfunction

  task automatic check_inst(int k, logic [P-1:0] ng, logic [5*P-1:0] mg, int cyv, int nfr);
    int w;
    int acc;
    int pw;
    string rs;
    w = int'(v);
    for (int i = 0; i < nfr; i++) if ((cyv >> i) & 1) w += 1 << (i*k);
    rs = (k == 3) ? "R1" : "R2";
    acc = 0;
    pw  = 1;
    for (int p = 0; p < P; p++) begin
      int d;
      d = dval(ng[p], mg[5*p +: 5]);
      acc += d * pw;
      pw  *= 8;
      chk("R3", $countones(mg[5*p +: 5]), 1);
      chk("R4", int'(ng[p] & mg[5*p]), 0);
      if (p == 0)        chk("R6", d, exp_digit(w, 0));
      else if (cyv == 0) chk("R9", d, exp_digit(w, p));
      else               chk("R5", d, exp_digit(w, p));
    end
    chk(rs, acc, w);
    chk("R7", int'(ng[P-1]), 0);
  endtask

  task automatic apply(logic [N-1:0] nv, logic [F3-1:0] nc3, logic [F6-1:0] nc6);
    @(posedge clk);
    v = nv;
    cy3 = nc3;
    cy6 = nc6;
    for (int i = 0; i < F3; i++) if (nv[3*i +: 3] == 3'b111) cy3[i] = 1'b0;     // R10
    for (int i = 0; i < F6; i++) if (nv[6*i +: 6] == 6'h3f)  cy6[i] = 1'b0;     // R10
    @(negedge clk);
    check_inst(3, neg3, mag3, int'(cy3), F3);
    check_inst(6, neg6, mag6, int'(cy6), F6);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    v = '0;
    cy3 = '0;
    cy6 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: zero input after reset gives zero digits
    for (int p = 0; p < P; p++) chk("R9", int'(mag3[5*p]) + int'(mag6[5*p]), 2);
    apply('0, '0, '0);
    apply('1, '0, '0);                           // R9 all ones, no carries
    apply(12'o0007, 4'b0001, 2'b01);             // R8 low cell all ones, carry passes in K=6
    apply(12'o0077, 4'b0000, 2'b01);             // R8 two-cell ripple blocked by contract
    apply(12'o0067, 4'b0100, 2'b01);             // R8 carry stops at cell with a zero bit
    apply(12'o0037, 4'b0001, 2'b01);             // R2 upper cell gets carry
    apply(12'o4444, 4'b1111, 2'b11);             // R5 negative digits with carries
    apply(12'o7776, 4'b1110, 2'b11);             // R7 near maximum value
    apply(12'o0003, 4'b0001, 2'b01);             // R6 low digit with carry
    for (int i = 0; i < 3000; i++)
      apply(N'($urandom), F3'($urandom), F6'($urandom));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule